// File: doc/BRIEF.md
# Fan-Monitor Register Bank with Coherent Two-Byte Reads

This block is the register file behind a fan-control and temperature-monitor device. Internal logic feeds it two live 16-bit measurements: an external-diode temperature and a tachometer count. An outside agent reaches the bank through a simple synchronous port with an address, write data, a write strobe, a read strobe and a registered read-data byte. The block also holds an eight-entry temperature/fan-setting lookup table, a configuration byte whose bit 5 write-protects that table, an averaging-filter select byte, and three fixed identification bytes.

Each measurement is 16 bits wide but is read one byte at a time, so the bank latches the second half when the first half is read. For temperature the high byte is read first: reading it returns the live high byte and, on the same clock edge, captures the live low byte into a shadow register. The low-byte address then returns that shadow. The tachometer works the other way round. Reading its low byte captures the live high byte, and the high-byte address returns the shadow. Software therefore always sees two halves from one sample, however much time passes between the two reads.

Top module: `fanmon_regbank`

## Requirements
- R1: After reset, `rd_data` is 00h, both shadow bytes read 00h, every temperature entry of the table reads 7Fh, every fan entry reads 3Fh, and the configuration (4Ah) and filter (BFh) bytes read 00h.
- R2: `rd_data` is registered. It takes the addressed value on the clock edge at which `rd_en` is sampled high, and holds its value on every edge at which `rd_en` is low, including edges with writes.
- R3: A read of address 10h returns `temp_meas[15:8]` and, on the same edge, copies `temp_meas[7:0]` into the temperature shadow.
- R4: A read of address 11h returns the temperature shadow. Repeated reads return the same value however the input changes, until the next read of 10h refreshes the shadow. A read of 10h refreshes it even if 11h was never read.
- R5: A read of address 20h returns `tach_meas[7:0]` and copies `tach_meas[15:8]` into the tach shadow. A read of 21h returns that shadow, which changes only on reads of 20h.
- R6: Table entry k (k = 1..8) has its temperature setting at 50h+2(k-1) and its fan setting at 51h+2(k-1). Temperature settings keep bits [6:0] and fan settings keep bits [5:0]. The other bits always read 0.
- R7: While bit 5 of the configuration byte at 4Ah is 1, writes to 50h..5Fh leave the table unchanged. While it is 0, such writes take effect.
- R8: The configuration byte at 4Ah keeps bits [5:0] and the filter select at BFh keeps bits [1:0]. All other bits read 0.
- R9: FDh reads the product ID (parameter, default 16h), FEh reads 5Dh and FFh reads 01h. Writes to them have no effect.
- R10: Every address not named in R3..R9 reads 00h. Writes to those addresses, to the measurement addresses and to the identification addresses change no readable state, the shadows included.
- R11: When a read and a write of the same address happen in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 8 | Register byte address for the read or write |
| wr_data | input | 8 | Byte to be written |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_data | output | 8 | Registered read data |
| temp_meas | input | 16 | Live external-diode temperature sample |
| tach_meas | input | 16 | Live tachometer count sample |

## Verification
The bench changes the measurement inputs between a trigger read and each partner read. A design that fed the partner address from the live input instead of the shadow, or that captured the shadow one cycle late, would return a byte from a different sample. It re-triggers without reading the partner, which catches a shadow that refreshes only after a partner read, and it checks that the temperature and tach trigger roles are not swapped. Writes are swept over every table register with the lock set and with it clear, so a reversed or missing write-protect shows up as a changed or frozen entry. Two full 256-address read sweeps catch decode holes, aliasing, unmasked unused bits and wrong reset values.

// File: rtl/fanmon_pkg.sv
package fanmon_pkg;
  localparam int BYTE_W = 8;
  localparam int MEAS_W = 2 * BYTE_W;

  localparam logic [7:0] A_TEMP_HI  = 8'h10;
  localparam logic [7:0] A_TEMP_LO  = 8'h11;
  localparam logic [7:0] A_TACH_LO  = 8'h20;
  localparam logic [7:0] A_TACH_HI  = 8'h21;
  localparam logic [7:0] A_CFG      = 8'h4A;
  localparam logic [7:0] A_LUT_BASE = 8'h50;
  localparam logic [7:0] A_AVG      = 8'hBF;
  localparam logic [7:0] A_PROD     = 8'hFD;
  localparam logic [7:0] A_MFG      = 8'hFE;
  localparam logic [7:0] A_REV      = 8'hFF;

  localparam int         CFG_LOCK_BIT = 5;
  localparam logic [7:0] CFG_MASK     = 8'h3F;
  localparam logic [7:0] AVG_MASK     = 8'h03;
  localparam logic [7:0] MFG_VALUE    = 8'h5D;
  localparam logic [7:0] REV_VALUE    = 8'h01;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TEMP_HI,
    SEL_TEMP_LO,
    SEL_TACH_LO,
    SEL_TACH_HI,
    SEL_CFG,
    SEL_LUT,
    SEL_AVG,
    SEL_PROD,
    SEL_MFG,
    SEL_REV
  } rsel_e;
endpackage

// File: rtl/fanmon_pair_latch.sv
module fanmon_pair_latch #(
  parameter int BYTE_W    = 8,
  parameter bit TRIG_HIGH = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [2*BYTE_W-1:0]   sample,
  input  logic                  trig_rd,
  output logic [BYTE_W-1:0]     trig_byte,
  output logic [BYTE_W-1:0]     held_byte
);
  logic [BYTE_W-1:0] partner_live;
  logic [BYTE_W-1:0] shadow_q;

  generate
    if (TRIG_HIGH) begin : g_high_first
      assign trig_byte    = sample[2*BYTE_W-1:BYTE_W];
      assign partner_live = sample[BYTE_W-1:0];
    end else begin : g_low_first
      assign trig_byte    = sample[BYTE_W-1:0];
      assign partner_live = sample[2*BYTE_W-1:BYTE_W];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (trig_rd) begin
      shadow_q <= partner_live;
    end
  end

  assign held_byte = shadow_q;
endmodule

// File: rtl/fanmon_lut.sv
module fanmon_lut #(
  parameter int ENTRIES = 8,
  parameter int BYTE_W  = 8,
  parameter int TEMP_W  = 7,
  parameter int FAN_W   = 6,
  localparam int REGS   = 2 * ENTRIES,
  localparam int IDX_W  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam logic [BYTE_W-1:0] TEMP_MASK = {BYTE_W{1'b1}} >> (BYTE_W - TEMP_W);
  localparam logic [BYTE_W-1:0] FAN_MASK  = {BYTE_W{1'b1}} >> (BYTE_W - FAN_W);

  logic [ENTRIES-1:0][BYTE_W-1:0] temp_rd;
  logic [ENTRIES-1:0][BYTE_W-1:0] fan_rd;

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic [BYTE_W-1:0] t_q;
      logic [BYTE_W-1:0] f_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          t_q <= TEMP_MASK;
          f_q <= FAN_MASK;
        end else if (wr_en) begin
          if (idx == IDX_W'(2 * e))     t_q <= wr_data & TEMP_MASK;
          if (idx == IDX_W'(2 * e + 1)) f_q <= wr_data & FAN_MASK;
        end
      end

      assign temp_rd[e] = t_q;
      assign fan_rd[e]  = f_q;
    end
  endgenerate

  assign rd_byte = idx[0] ? fan_rd[idx[IDX_W-1:1]] : temp_rd[idx[IDX_W-1:1]];
endmodule

// File: rtl/fanmon_ctrl_regs.sv
module fanmon_ctrl_regs
  import fanmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cfg,
  input  logic              wr_avg,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] cfg_q,
  output logic [BYTE_W-1:0] avg_q,
  output logic              lut_lock
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      avg_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data & CFG_MASK;
      if (wr_avg) avg_q <= wr_data & AVG_MASK;
    end
  end

  assign lut_lock = cfg_q[CFG_LOCK_BIT];
endmodule

// File: rtl/fanmon_regbank.sv
module fanmon_regbank
  import fanmon_pkg::*;
#(
  parameter int         LUT_ENTRIES = 8,
  parameter int         TEMP_W      = 7,
  parameter int         FAN_W       = 6,
  parameter logic [7:0] PRODUCT_ID  = 8'h16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  addr,
  input  logic [7:0]  wr_data,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  input  logic [15:0] temp_meas,
  input  logic [15:0] tach_meas
);
  localparam int         LUT_REGS = 2 * LUT_ENTRIES;
  localparam int         IDX_W    = $clog2(LUT_REGS);
  localparam logic [7:0] LUT_END  = A_LUT_BASE + 8'(LUT_REGS);

  rsel_e             sel;
  logic [IDX_W-1:0]  lut_idx;
  logic [BYTE_W-1:0] lut_byte;
  logic [BYTE_W-1:0] cfg_q;
  logic [BYTE_W-1:0] avg_q;
  logic              lut_lock;
  logic [BYTE_W-1:0] temp_hi_live, temp_lo_held;
  logic [BYTE_W-1:0] tach_lo_live, tach_hi_held;
  logic [BYTE_W-1:0] rd_next;

  always_comb begin
    sel = SEL_NONE;
    if (addr >= A_LUT_BASE && addr < LUT_END) begin
      sel = SEL_LUT;
    end else begin
      case (addr)
        A_TEMP_HI: sel = SEL_TEMP_HI;
        A_TEMP_LO: sel = SEL_TEMP_LO;
        A_TACH_LO: sel = SEL_TACH_LO;
        A_TACH_HI: sel = SEL_TACH_HI;
        A_CFG:     sel = SEL_CFG;
        A_AVG:     sel = SEL_AVG;
        A_PROD:    sel = SEL_PROD;
        A_MFG:     sel = SEL_MFG;
        A_REV:     sel = SEL_REV;
        default:   sel = SEL_NONE;
      endcase
    end
  end

  assign lut_idx = IDX_W'(addr - A_LUT_BASE);

  fanmon_pair_latch #(.BYTE_W(BYTE_W), .TRIG_HIGH(1'b1)) u_temp_pair (
    .clk       (clk),
    .rst       (rst),
    .sample    (temp_meas),
    .trig_rd   (rd_en && sel == SEL_TEMP_HI),
    .trig_byte (temp_hi_live),
    .held_byte (temp_lo_held)
  );

  fanmon_pair_latch #(.BYTE_W(BYTE_W), .TRIG_HIGH(1'b0)) u_tach_pair (
    .clk       (clk),
    .rst       (rst),
    .sample    (tach_meas),
    .trig_rd   (rd_en && sel == SEL_TACH_LO),
    .trig_byte (tach_lo_live),
    .held_byte (tach_hi_held)
  );

  fanmon_lut #(
    .ENTRIES (LUT_ENTRIES),
    .BYTE_W  (BYTE_W),
    .TEMP_W  (TEMP_W),
    .FAN_W   (FAN_W)
  ) u_lut (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en && sel == SEL_LUT && !lut_lock),
    .idx     (lut_idx),
    .wr_data (wr_data),
    .rd_byte (lut_byte)
  );

  fanmon_ctrl_regs u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_cfg   (wr_en && sel == SEL_CFG),
    .wr_avg   (wr_en && sel == SEL_AVG),
    .wr_data  (wr_data),
    .cfg_q    (cfg_q),
    .avg_q    (avg_q),
    .lut_lock (lut_lock)
  );

  always_comb begin
    case (sel)
      SEL_TEMP_HI: rd_next = temp_hi_live;
      SEL_TEMP_LO: rd_next = temp_lo_held;
      SEL_TACH_LO: rd_next = tach_lo_live;
      SEL_TACH_HI: rd_next = tach_hi_held;
      SEL_CFG:     rd_next = cfg_q;
      SEL_LUT:     rd_next = lut_byte;
      SEL_AVG:     rd_next = avg_q;
      SEL_PROD:    rd_next = PRODUCT_ID;
      SEL_MFG:     rd_next = MFG_VALUE;
      SEL_REV:     rd_next = REV_VALUE;
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_next;
    end
  end
endmodule

// File: rtl/fanmon_regbank_chk.sv
module fanmon_regbank_chk
  import fanmon_pkg::*;
#(
  parameter int         LUT_ENTRIES = 8,
  parameter int         FAN_W       = 6,
  parameter logic [7:0] PRODUCT_ID  = 8'h16
) (
  input logic        clk,
  input logic        rst,
  input logic [7:0]  addr,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic [15:0] temp_meas,
  input logic [15:0] tach_meas
);
  localparam logic [7:0] LUT_END = A_LUT_BASE + 8'(2 * LUT_ENTRIES);

  logic [7:0] ref_temp_lo;
  logic [7:0] ref_tach_hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_temp_lo <= '0;
      ref_tach_hi <= '0;
    end else begin
      if (rd_en && addr == A_TEMP_HI) ref_temp_lo <= temp_meas[7:0];
      if (rd_en && addr == A_TACH_LO) ref_tach_hi <= tach_meas[15:8];
    end
  end

  AST_READ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data)); // R2
  AST_TEMP_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_TEMP_HI |=> rd_data == $past(temp_meas[15:8])); // R3
  AST_TEMP_PARTNER: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_TEMP_LO |=> rd_data == $past(ref_temp_lo)); // R4
  AST_TACH_TRIGGER: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_TACH_LO |=> rd_data == $past(tach_meas[7:0])); // R5
  AST_TACH_PARTNER: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_TACH_HI |=> rd_data == $past(ref_tach_hi)); // R5
  AST_FAN_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr >= A_LUT_BASE && addr < LUT_END && addr[0]
    |=> (rd_data >> FAN_W) == 8'h00); // R6
  AST_ID_BYTES: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_MFG |=> rd_data == MFG_VALUE); // R9
  AST_PROD_BYTE: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr == A_PROD |=> rd_data == PRODUCT_ID); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_en && addr >= 8'hC0 && addr < A_PROD |=> rd_data == 8'h00); // R10
endmodule

bind fanmon_regbank fanmon_regbank_chk #(
  .LUT_ENTRIES (LUT_ENTRIES),
  .FAN_W       (FAN_W),
  .PRODUCT_ID  (PRODUCT_ID)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .addr      (addr),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .temp_meas (temp_meas),
  .tach_meas (tach_meas)
);

// File: tb/fanmon_regbank_tb.sv
`timescale 1ns/1ps
module fanmon_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  addr = '0;
  logic [7:0]  wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_data;
  logic [15:0] temp_meas = '0;
  logic [15:0] tach_meas = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_temp [8];
  logic [7:0] m_fan  [8];
  logic [7:0] m_cfg, m_avg, s_tlo, s_thi;

  always #2.5 clk = ~clk;

  fanmon_regbank u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .temp_meas(temp_meas), .tach_meas(tach_meas)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a >= 8'h50 && a < 8'h60) begin
      if (a[0]) return m_fan[(a - 8'h50) >> 1];
      else      return m_temp[(a - 8'h50) >> 1];
    end
    case (a)
      8'h10: return temp_meas[15:8];
      8'h11: return s_tlo;
      8'h20: return tach_meas[7:0];
      8'h21: return s_thi;
      8'h4A: return m_cfg;
      8'hBF: return m_avg;
      8'hFD: return 8'h16;
      8'hFE: return 8'h5D;
      8'hFF: return 8'h01;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin
      m_temp[i] = 8'h7F;
      m_fan[i]  = 8'h3F;
    end
    m_cfg = 0; m_avg = 0; s_tlo = 0; s_thi = 0;
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] v);
    if (a >= 8'h50 && a < 8'h60 && !m_cfg[5]) begin
      if (a[0]) m_fan[(a - 8'h50) >> 1]  = v & 8'h3F;
      else      m_temp[(a - 8'h50) >> 1] = v & 8'h7F;
    end
    if (a == 8'h4A) m_cfg = v & 8'h3F;
    if (a == 8'hBF) m_avg = v & 8'h03;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wr_data = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    model_write(a, v);
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [7:0] e, d;
    e = exp_rd(a);
    rd(a, d);
    chk(tag, d, e);
    if (a == 8'h10) s_tlo = temp_meas[7:0];
    if (a == 8'h20) s_thi = tach_meas[15:8];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, snap;
    model_reset();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", rd_data, 8'h00);
    temp_meas = 16'hA55A; tach_meas = 16'h3CC3;
    rd_chk(8'h11, "R1 temp shadow reset");
    rd_chk(8'h21, "R1 tach shadow reset");
    for (int a = 0; a < 256; a++) rd_chk(8'(a), "R1 R6 R8 R9 R10 reset sweep");

    // R2: hold across idle and write cycles
    rd(8'hFE, snap);
    repeat (3) @(negedge clk);
    chk("R2 hold idle", rd_data, snap);
    wr(8'h52, 8'h11);
    chk("R2 hold during write", rd_data, snap);

    // R6: every table register, two patterns
    for (int i = 0; i < 16; i++) wr(8'(8'h50 + i), 8'(i * 37 + 8'hC5));
    for (int i = 0; i < 16; i++) rd_chk(8'(8'h50 + i), "R6 table pattern");
    for (int i = 0; i < 16; i++) wr(8'(8'h50 + i), 8'hFF);
    for (int i = 0; i < 16; i++) rd_chk(8'(8'h50 + i), "R6 table masking");

    // R8 / R7: lock set, writes ignored
    wr(8'h4A, 8'hFF);
    rd_chk(8'h4A, "R8 cfg mask");
    for (int i = 0; i < 16; i++) wr(8'(8'h50 + i), 8'(i * 11));
    for (int i = 0; i < 16; i++) rd_chk(8'(8'h50 + i), "R7 locked table");
    wr(8'h4A, 8'hDF);
    rd_chk(8'h4A, "R8 cfg lock clear");
    for (int i = 0; i < 16; i++) wr(8'(8'h50 + i), 8'(i * 11));
    for (int i = 0; i < 16; i++) rd_chk(8'(8'h50 + i), "R7 unlocked table");
    wr(8'hBF, 8'hFE);
    rd_chk(8'hBF, "R8 filter mask");

    // R9 / R10: writes to read-only and unmapped addresses
    rd_chk(8'h10, "R3 prime temp shadow");
    rd_chk(8'h20, "R5 prime tach shadow");
    foreach (d[i]) begin end
    wr(8'hFD, 8'h00); wr(8'hFE, 8'h00); wr(8'hFF, 8'hAA);
    wr(8'h10, 8'h77); wr(8'h11, 8'h77); wr(8'h20, 8'h77); wr(8'h21, 8'h77);
    wr(8'h00, 8'hFF); wr(8'h60, 8'hFF); wr(8'hC7, 8'hFF); wr(8'h4B, 8'hFF);
    rd_chk(8'hFD, "R9 product ID after write");
    rd_chk(8'hFE, "R9 maker ID after write");
    rd_chk(8'hFF, "R9 revision after write");
    rd_chk(8'h11, "R10 temp shadow untouched");
    rd_chk(8'h21, "R10 tach shadow untouched");
    rd_chk(8'h60, "R10 unmapped reads zero");

    // R3 / R4: temperature interlock with changing input
    temp_meas = 16'h1234;
    rd_chk(8'h10, "R3 temp trigger");
    temp_meas = 16'h5678;
    rd_chk(8'h11, "R4 partner after change");
    temp_meas = 16'h9ABC;
    rd_chk(8'h11, "R4 partner repeat");
    rd_chk(8'h20, "R4 tach read leaves temp shadow");
    rd_chk(8'h11, "R4 partner after other trigger");
    temp_meas = 16'hDEF0;
    rd_chk(8'h10, "R4 retrigger one");
    temp_meas = 16'h0F1E;
    rd_chk(8'h10, "R4 retrigger two");
    temp_meas = 16'hFFFF;
    rd_chk(8'h11, "R4 refresh without partner read");

    // R5: tachometer interlock, low byte is the trigger
    tach_meas = 16'hBEEF;
    rd_chk(8'h20, "R5 tach trigger");
    tach_meas = 16'h0102;
    rd_chk(8'h21, "R5 tach partner");
    rd_chk(8'h10, "R5 temp read leaves tach shadow");
    rd_chk(8'h21, "R5 tach partner repeat");
    for (int k = 0; k < 8; k++) begin
      tach_meas = 16'(k * 16'h1111 + 16'h0F0F);
      temp_meas = 16'(k * 16'h2345 + 16'h0123);
      rd_chk(8'h20, "R5 tach trigger sweep");
      rd_chk(8'h10, "R3 temp trigger sweep");
      tach_meas = ~tach_meas; temp_meas = ~temp_meas;
      rd_chk(8'h21, "R5 tach partner sweep");
      rd_chk(8'h11, "R4 temp partner sweep");
    end

    // R11: read and write in the same cycle
    @(negedge clk); addr = 8'h57; wr_data = 8'h2A; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    chk("R11 read sees old value", rd_data, m_fan[3]);
    model_write(8'h57, 8'h2A);
    rd_chk(8'h57, "R11 new value visible");

    for (int a = 0; a < 256; a++) rd_chk(8'(a), "R6 R8 R9 R10 final sweep");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule